// File: doc/BRIEF.md
# Outstanding Read Tracker with Completion Timeout

This block ends single-beat AXI4 reads on a slave port and turns each accepted read into one memory-read request on an outbound request port. The request carries the captured address and a small tag. Up to eight such reads may wait for their completions at the same time. Each one owns a table slot that holds its state, its own timeout counter and, once its completion is in, its data and status.

Completions come back on an inbound port, each carrying a tag, a status flag and one data word. They may arrive in any order. A completion is captured in the slot that its tag names. R beats leave strictly in the order in which the reads were accepted, so a completion for a younger read waits in its slot until every older read has been returned. A read whose completion does not come within a parameterised number of cycles after its request left is answered with a slave-error response. Any completion that arrives for it later is dropped. A completion that reports failure is also answered with a slave error.

Top module: `read_tracker`

## Requirements
- R1: `s_arready` is high exactly when fewer than N_SLOTS reads are outstanding and the request register is either empty or being taken in the same cycle (`req_ready` high); a read is accepted on a cycle where `s_arvalid` and `s_arready` are both high.
- R2: Each accepted read gives exactly one request on the request port. `req_valid` rises in the cycle after the acceptance, carrying the accepted address and the read's tag, and `req_valid`, `req_addr` and `req_tag` hold until the cycle in which `req_ready` is high.
- R3: After reset, tags are handed out in acceptance order as 0, 1, 2, ... and wrap modulo N_SLOTS. A tag becomes free again in the cycle its R beat is taken.
- R4: No more than N_SLOTS (8 by default) reads are ever outstanding, and `s_arready` stays low while all of them are outstanding.
- R5: A completion with `cpl_err` = 0 whose tag names a read that has been issued and is still waiting is captured. That read is returned with `s_rresp` = 2'b00 (OKAY) and `s_rdata` equal to `cpl_data`.
- R6: R beats are returned in acceptance order whatever the order of the completions. `s_rvalid`, `s_rdata` and `s_rresp` hold until `s_rready` is high.
- R7: The timeout counter of a read starts at the cycle its request is taken on the request port. A completion is accepted on any of the TMO_CYCLES cycles that follow. If none has come by the last of them, the read is returned with `s_rresp` = 2'b10 (SLVERR) and `s_rdata` = 0.
- R8: A completion is ignored, with no R beat and no change to any data returned, if its tag names a read that already has its answer (timed out or completed), a read whose request has not yet been taken, or no outstanding read at all.
- R9: A completion with `cpl_err` = 1 makes its read return `s_rresp` = 2'b10 (SLVERR) with `s_rdata` = 0.
- R10: During and right after reset, `s_arready` = 1, `s_rvalid` = 0 and `req_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | ADDR_W | Read address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, 2'b00 OKAY, 2'b10 SLVERR |
| req_valid | output | 1 | Memory-read request valid |
| req_ready | input | 1 | Memory-read request ready |
| req_addr | output | ADDR_W | Request address |
| req_tag | output | TAG_W | Request tag |
| cpl_valid | input | 1 | Completion valid, always accepted |
| cpl_tag | input | TAG_W | Tag of the read being completed |
| cpl_err | input | 1 | 1 = completion reports failure |
| cpl_data | input | DATA_W | Completion data |

## Verification
A slot stuck in the wrong state shows up at the R port at the next head-of-line turn. The beat either never comes, which stalls every younger read behind it, or comes early with the wrong response. A corrupted tag pointer shows up in the very next request, as an out-of-sequence `req_tag`, and a corrupted occupancy count shows up at once as a wrong `s_arready` level. The bench therefore predicts `s_arready`, the request port and the R port every cycle, so any of these faults is reported within the cycle it first becomes visible. Timer faults are pinned by completions placed on the last accepted cycle and on the first cycle after it.

// File: rtl/rdtrk_pkg.sv
package rdtrk_pkg;

   typedef enum logic [1:0] {
      SL_IDLE = 2'd0,   // slot free
      SL_WAIT = 2'd1,   // accepted, request not yet taken
      SL_PEND = 2'd2,   // request taken, timer running
      SL_DONE = 2'd3    // answer held, waiting for its R turn
   } slot_st_e;

   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_SLVERR = 2'b10;

endpackage

// File: rtl/rdtrk_tag_ring.sv
// Tags are retired in the order they were handed out, so the free tags
// always form one contiguous run: a write and a read pointer suffice.
module rdtrk_tag_ring #(
   parameter  int N_SLOTS = 8,
   localparam int TAG_W   = $clog2(N_SLOTS),
   localparam int OCC_W   = $clog2(N_SLOTS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             alloc,
   input  logic             retire,
   output logic [TAG_W-1:0] wr_tag,
   output logic [TAG_W-1:0] rd_tag,
   output logic [OCC_W-1:0] occ,
   output logic             full
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_tag <= '0;
         rd_tag <= '0;
         occ    <= '0;
      end else begin
         if (alloc)  wr_tag <= wr_tag + 1'b1;
         if (retire) rd_tag <= rd_tag + 1'b1;
         case ({alloc, retire})
            2'b10:   occ <= occ + 1'b1;
            2'b01:   occ <= occ - 1'b1;
            default: occ <= occ;
         endcase
      end
   end

   assign full = (occ == OCC_W'(N_SLOTS));

endmodule

// File: rtl/rdtrk_req_stage.sv
// One-entry output register for the outbound request port.
module rdtrk_req_stage #(
   parameter int ADDR_W = 32,
   parameter int TAG_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [TAG_W-1:0]  load_tag,
   output logic              can_load,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ADDR_W-1:0] out_addr,
   output logic [TAG_W-1:0]  out_tag
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_addr  <= '0;
         out_tag   <= '0;
      end else if (load) begin
         out_valid <= 1'b1;
         out_addr  <= load_addr;
         out_tag   <= load_tag;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   assign can_load = !out_valid || out_ready;

endmodule

// File: rtl/rdtrk_slot.sv
// One pending-read entry: life-cycle state, timeout counter, answer.
module rdtrk_slot
   import rdtrk_pkg::*;
#(
   parameter  int DATA_W     = 32,
   parameter  int TMO_CYCLES = 64,
   localparam int CNT_W      = $clog2(TMO_CYCLES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc,
   input  logic              issue,
   input  logic              cpl_hit,
   input  logic              cpl_err,
   input  logic [DATA_W-1:0] cpl_data,
   input  logic              retire,
   output logic              done,
   output logic              err,
   output logic [DATA_W-1:0] data
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(TMO_CYCLES - 1);

   slot_st_e         st;
   logic [CNT_W-1:0] tmr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= SL_IDLE;
         tmr  <= '0;
         err  <= 1'b0;
         data <= '0;
      end else begin
         case (st)
            SL_IDLE: if (alloc) st <= SL_WAIT;
            SL_WAIT: if (issue) begin
               st  <= SL_PEND;
               tmr <= '0;
            end
            SL_PEND: begin
               if (cpl_hit) begin
                  st   <= SL_DONE;
                  err  <= cpl_err;
                  data <= cpl_err ? '0 : cpl_data;
               end else if (tmr == LAST) begin
                  st   <= SL_DONE;
                  err  <= 1'b1;
                  data <= '0;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            SL_DONE: if (retire) st <= SL_IDLE;
            default: st <= SL_IDLE;
         endcase
      end
   end

   assign done = (st == SL_DONE);

endmodule

// File: rtl/read_tracker.sv
module read_tracker
   import rdtrk_pkg::*;
#(
   parameter  int ADDR_W     = 32,
   parameter  int DATA_W     = 32,
   parameter  int N_SLOTS    = 8,
   parameter  int TMO_CYCLES = 64,
   localparam int TAG_W      = $clog2(N_SLOTS),
   localparam int OCC_W      = $clog2(N_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              s_arvalid,
   output logic              s_arready,
   input  logic [ADDR_W-1:0] s_araddr,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic [TAG_W-1:0]  req_tag,
   input  logic              cpl_valid,
   input  logic [TAG_W-1:0]  cpl_tag,
   input  logic              cpl_err,
   input  logic [DATA_W-1:0] cpl_data
);

   // elaboration-time parameter checks
   if (N_SLOTS < 2 || (N_SLOTS & (N_SLOTS - 1)) != 0) begin : g_bad_slots
      $error("read_tracker: N_SLOTS must be a power of two, at least 2");
   end
   if (TMO_CYCLES < 2) begin : g_bad_tmo
      $error("read_tracker: TMO_CYCLES must be at least 2");
   end
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("read_tracker: widths must be positive");
   end

   logic             ar_fire, req_fire, r_fire;
   logic             can_load, full;
   logic [TAG_W-1:0] wr_tag, rd_tag;
   logic [OCC_W-1:0] occ;

   logic              slot_done [N_SLOTS];
   logic              slot_err  [N_SLOTS];
   logic [DATA_W-1:0] slot_data [N_SLOTS];

   assign s_arready = !full && can_load;
   assign ar_fire   = s_arvalid && s_arready;
   assign req_fire  = req_valid && req_ready;
   assign r_fire    = s_rvalid && s_rready;

   rdtrk_tag_ring #(.N_SLOTS(N_SLOTS)) u_ring (
      .clk    (clk),
      .rst_n  (rst_n),
      .alloc  (ar_fire),
      .retire (r_fire),
      .wr_tag (wr_tag),
      .rd_tag (rd_tag),
      .occ    (occ),
      .full   (full)
   );

   rdtrk_req_stage #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_req (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ar_fire),
      .load_addr (s_araddr),
      .load_tag  (wr_tag),
      .can_load  (can_load),
      .out_valid (req_valid),
      .out_ready (req_ready),
      .out_addr  (req_addr),
      .out_tag   (req_tag)
   );

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      localparam logic [TAG_W-1:0] ID = TAG_W'(g);
      rdtrk_slot #(.DATA_W(DATA_W), .TMO_CYCLES(TMO_CYCLES)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .alloc    (ar_fire   && (wr_tag  == ID)),
         .issue    (req_fire  && (req_tag == ID)),
         .cpl_hit  (cpl_valid && (cpl_tag == ID)),
         .cpl_err  (cpl_err),
         .cpl_data (cpl_data),
         .retire   (r_fire    && (rd_tag  == ID)),
         .done     (slot_done[g]),
         .err      (slot_err[g]),
         .data     (slot_data[g])
      );
   end

   // head-of-line return: the oldest outstanding slot drives the R port
   assign s_rvalid = slot_done[rd_tag];
   assign s_rdata  = slot_data[rd_tag];
   assign s_rresp  = slot_err[rd_tag] ? RESP_SLVERR : RESP_OKAY;

endmodule

// File: rtl/read_tracker_chk.sv
module read_tracker_chk #(
   parameter  int ADDR_W  = 32,
   parameter  int DATA_W  = 32,
   parameter  int N_SLOTS = 8,
   localparam int TAG_W   = $clog2(N_SLOTS),
   localparam int OCC_W   = $clog2(N_SLOTS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              s_arvalid,
   input logic              s_arready,
   input logic              s_rvalid,
   input logic              s_rready,
   input logic [DATA_W-1:0] s_rdata,
   input logic [1:0]        s_rresp,
   input logic              req_valid,
   input logic              req_ready,
   input logic [ADDR_W-1:0] req_addr,
   input logic [TAG_W-1:0]  req_tag,
   input logic [OCC_W-1:0]  occ
);

   logic ar_hs, r_hs;
   assign ar_hs = s_arvalid && s_arready;
   assign r_hs  = s_rvalid && s_rready;

   a_r4_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == OCC_W'(N_SLOTS)) |-> !s_arready);

   a_r4_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OCC_W'(N_SLOTS));

   a_r1_occ_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_hs && !r_hs) |=> (occ == OCC_W'($past(occ) + 1)));

   a_r3_occ_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (!ar_hs && r_hs) |=> (occ == OCC_W'($past(occ) - 1)));

   a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=>
         (req_valid && $stable(req_addr) && $stable(req_tag)));

   a_r6_r_held: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rvalid && !s_rready) |=>
         (s_rvalid && $stable(s_rdata) && $stable(s_rresp)));

   a_r10_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == '0) |-> (!s_rvalid && !req_valid));

   a_r9_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      (s_rvalid && s_rresp == 2'b10) |-> (s_rdata == '0));

   a_r5_resp_legal: assert property (@(posedge clk) disable iff (!rst_n)
      s_rvalid |-> (s_rresp == 2'b00 || s_rresp == 2'b10));

endmodule

bind read_tracker read_tracker_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .N_SLOTS (N_SLOTS)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .s_arvalid (s_arvalid),
   .s_arready (s_arready),
   .s_rvalid  (s_rvalid),
   .s_rready  (s_rready),
   .s_rdata   (s_rdata),
   .s_rresp   (s_rresp),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_addr  (req_addr),
   .req_tag   (req_tag),
   .occ       (occ)
);

// File: tb/read_tracker_tb.sv
`timescale 1ns/1ps
module read_tracker_tb;

   localparam int TMO = 20;
   localparam int NS  = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ar_v = 1'b0;
   logic [31:0] ar_addr = '0;
   logic        r_rdy = 1'b0;
   logic        rq_rdy = 1'b0;
   logic        cp_v = 1'b0;
   logic [2:0]  cp_tag = '0;
   logic        cp_err = 1'b0;
   logic [31:0] cp_data = '0;

   logic        s_arready, s_rvalid, req_valid;
   logic [31:0] s_rdata, req_addr;
   logic [1:0]  s_rresp;
   logic [2:0]  req_tag;

   always #2 clk = ~clk;   // 250 MHz

   read_tracker #(.ADDR_W(32), .DATA_W(32), .N_SLOTS(NS), .TMO_CYCLES(TMO)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .s_arvalid(ar_v), .s_arready(s_arready), .s_araddr(ar_addr),
      .s_rvalid(s_rvalid), .s_rready(r_rdy), .s_rdata(s_rdata), .s_rresp(s_rresp),
      .req_valid(req_valid), .req_ready(rq_rdy), .req_addr(req_addr), .req_tag(req_tag),
      .cpl_valid(cp_v), .cpl_tag(cp_tag), .cpl_err(cp_err), .cpl_data(cp_data)
   );

   int total = 0;
   int fails = 0;

   // behavioural reference model
   int          ord[$];          // outstanding tags, oldest first
   int          iss_at[int];     // tag -> cycle its request was taken
   logic [31:0] res_data[int];   // tag -> answer data
   bit          res_err[int];    // tag -> answer is an error
   bit          m_rq_v = 0;
   logic [31:0] m_rq_addr = '0;
   int          m_rq_tag = 0;
   int          m_next = 0;
   int          cyc = 0;
   bit          last_ar_fire = 0;

   // what the ports actually produced
   logic [31:0] beat_data[$];
   logic [1:0]  beat_resp[$];
   int          req_tag_log[$];
   logic [31:0] req_addr_log[$];

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=%0h exp=%0h (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   task automatic step();
      bit          e_ar, e_rv, ar_f, rq_f, r_f;
      logic [31:0] e_rd;
      logic [1:0]  e_rr;
      int          expired[$];
      @(negedge clk);
      #1;
      e_ar = (ord.size() < NS) && (!m_rq_v || rq_rdy);
      e_rv = (ord.size() > 0) && res_err.exists(ord[0]);
      e_rd = e_rv ? res_data[ord[0]] : '0;
      e_rr = (e_rv && res_err[ord[0]]) ? 2'b10 : 2'b00;

      chk(s_arready === e_ar, "R1/R4", "s_arready", 64'(s_arready), 64'(e_ar));
      chk(req_valid === m_rq_v &&
          (!m_rq_v || (req_addr === m_rq_addr && req_tag === 3'(m_rq_tag))),
          "R2/R3", "req {valid,addr,tag}",
          {req_valid, req_addr, req_tag}, {m_rq_v, m_rq_addr, 3'(m_rq_tag)});
      chk(s_rvalid === e_rv && (!e_rv || (s_rdata === e_rd && s_rresp === e_rr)),
          "R6", "r {valid,resp,data}",
          {s_rvalid, s_rresp, s_rdata}, {e_rv, e_rr, e_rd});

      if (s_rvalid === 1'b1 && r_rdy) begin
         beat_data.push_back(s_rdata);
         beat_resp.push_back(s_rresp);
      end
      if (req_valid === 1'b1 && rq_rdy) begin
         req_tag_log.push_back(int'(req_tag));
         req_addr_log.push_back(req_addr);
      end

      ar_f = ar_v && e_ar;
      rq_f = m_rq_v && rq_rdy;
      r_f  = e_rv && r_rdy;
      last_ar_fire = ar_f;

      if (cp_v && iss_at.exists(int'(cp_tag))) begin
         res_err[int'(cp_tag)]  = cp_err;
         res_data[int'(cp_tag)] = cp_err ? '0 : cp_data;
         iss_at.delete(int'(cp_tag));
      end
      foreach (iss_at[t]) if (cyc - iss_at[t] == TMO) expired.push_back(t);
      foreach (expired[i]) begin
         res_err[expired[i]]  = 1'b1;
         res_data[expired[i]] = '0;
         iss_at.delete(expired[i]);
      end
      if (r_f) begin
         res_err.delete(ord[0]);
         res_data.delete(ord[0]);
         void'(ord.pop_front());
      end
      if (rq_f) iss_at[m_rq_tag] = cyc;
      if (ar_f) begin
         m_rq_v = 1'b1;
         m_rq_addr = ar_addr;
         m_rq_tag = m_next;
         ord.push_back(m_next);
         m_next = (m_next + 1) % NS;
      end else if (rq_f) begin
         m_rq_v = 1'b0;
      end
      cyc++;
      @(posedge clk);
      #1;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic do_ar(input logic [31:0] a, output int tg);
      ar_v = 1'b1;
      ar_addr = a;
      tg = m_next;
      do step(); while (!last_ar_fire);
      ar_v = 1'b0;
   endtask

   task automatic cpl(input int tg, input bit e, input logic [31:0] d);
      cp_v = 1'b1; cp_tag = 3'(tg); cp_err = e; cp_data = d;
      step();
      cp_v = 1'b0;
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", total - fails, total);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog all-requirements act=hung exp=finished");
      summary();
      $finish;
   end

   initial begin
      int t[NS];
      int tg, tg2, base, rbase, fires;

      // reset (R10)
      repeat (3) @(posedge clk);
      chk(s_arready === 1'b1, "R10", "arready in reset", 64'(s_arready), 1);
      chk(s_rvalid === 1'b0, "R10", "rvalid in reset", 64'(s_rvalid), 0);
      chk(req_valid === 1'b0, "R10", "req_valid in reset", 64'(req_valid), 0);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      chk(s_arready === 1'b1 && s_rvalid === 1'b0 && req_valid === 1'b0, "R10",
          "outputs after reset", {s_arready, s_rvalid, req_valid}, 64'b100);

      // single read (R2, R3, R5)
      rq_rdy = 1'b1; r_rdy = 1'b1;
      base = beat_data.size(); rbase = req_tag_log.size();
      do_ar(32'h0000_1000, tg);
      idle(2);
      cpl(tg, 1'b0, 32'h1234_5678);
      idle(2);
      chk(req_tag_log.size() == rbase + 1 && req_tag_log[rbase] == 0, "R3",
          "first tag", 64'(req_tag_log[rbase]), 0);
      chk(req_addr_log[rbase] === 32'h0000_1000, "R2", "request address",
          64'(req_addr_log[rbase]), 64'h1000);
      chk(beat_data.size() == base + 1 && beat_resp[base] === 2'b00 &&
          beat_data[base] === 32'h1234_5678, "R5", "ok beat",
          {beat_resp[base], beat_data[base]}, {2'b00, 32'h1234_5678});

      // unmatched completion while empty (R8)
      base = beat_data.size();
      cpl(5, 1'b0, 32'hBAD0_0001);
      idle(3);
      chk(beat_data.size() == base && s_rvalid === 1'b0, "R8", "stray completion beats",
          64'(beat_data.size() - base), 0);

      // fill all slots, reverse completion order (R3, R4, R6)
      r_rdy = 1'b0;
      base = beat_data.size(); rbase = req_tag_log.size();
      for (int i = 0; i < NS; i++) do_ar(32'h2000 + 32'(4 * i), t[i]);
      ar_v = 1'b1; ar_addr = 32'h9999_0000; fires = 0;
      for (int i = 0; i < 3; i++) begin
         step();
         if (last_ar_fire) fires++;
      end
      ar_v = 1'b0;
      chk(fires == 0 && s_arready === 1'b0, "R4", "accept while full",
          64'(fires), 0);
      for (int i = NS - 1; i >= 0; i--) cpl(t[i], 1'b0, 32'hA0 + 32'(i));
      idle(2);
      r_rdy = 1'b1;
      idle(NS + 2);
      for (int i = 0; i < NS; i++) begin
         chk(beat_data[base + i] === 32'hA0 + 32'(i) && beat_resp[base + i] === 2'b00,
             "R6", "in-order beat data", 64'(beat_data[base + i]), 64'(32'hA0 + 32'(i)));
         chk(req_tag_log[rbase + i] == (1 + i) % NS, "R3", "consecutive tag",
             64'(req_tag_log[rbase + i]), 64'((1 + i) % NS));
      end

      // failed completion (R9)
      base = beat_data.size();
      do_ar(32'h3000, tg);
      idle(1);
      cpl(tg, 1'b1, 32'hDEAD_BEEF);
      idle(2);
      chk(beat_resp[base] === 2'b10 && beat_data[base] === '0, "R9", "error beat",
          {beat_resp[base], beat_data[base]}, {2'b10, 32'h0});

      // completion on the last allowed cycle, then one cycle late (R7, R8)
      base = beat_data.size();
      do_ar(32'h4000, tg);
      step();                 // request taken here
      idle(TMO - 1);
      cpl(tg, 1'b0, 32'h5555_0001);
      idle(2);
      chk(beat_resp[base] === 2'b00 && beat_data[base] === 32'h5555_0001, "R7",
          "completion on last cycle", {beat_resp[base], beat_data[base]},
          {2'b00, 32'h5555_0001});
      r_rdy = 1'b0;
      do_ar(32'h4100, tg2);
      step();
      idle(TMO);
      cpl(tg2, 1'b0, 32'h6666_0002);   // one cycle too late
      idle(2);
      chk(s_rvalid === 1'b1 && s_rresp === 2'b10 && s_rdata === '0, "R8",
          "late completion dropped", {s_rresp, s_rdata}, {2'b10, 32'h0});
      r_rdy = 1'b1;
      idle(2);
      chk(beat_data.size() == base + 2 && beat_resp[base + 1] === 2'b10, "R7",
          "timeout beat", 64'(beat_resp[base + 1]), 64'b10);

      // request backpressure delays both acceptance and the timer (R1, R7)
      rq_rdy = 1'b0;
      base = beat_data.size();
      do_ar(32'h5000, tg);
      ar_v = 1'b1; ar_addr = 32'h5004; fires = 0;
      for (int i = 0; i < 3; i++) begin
         step();
         if (last_ar_fire) fires++;
      end
      chk(fires == 0, "R1", "accept with request register blocked", 64'(fires), 0);
      ar_v = 1'b0;
      idle(TMO + 5);
      rq_rdy = 1'b1;
      ar_v = 1'b1;
      tg2 = m_next;
      do step(); while (!last_ar_fire);
      ar_v = 1'b0;
      idle(3);
      cpl(tg2, 1'b0, 32'h7777_0002);
      cpl(tg, 1'b0, 32'h7777_0001);
      idle(3);
      chk(beat_resp[base] === 2'b00 && beat_data[base] === 32'h7777_0001, "R7",
          "timer waits for issue", {beat_resp[base], beat_data[base]},
          {2'b00, 32'h7777_0001});
      chk(beat_data[base + 1] === 32'h7777_0002, "R6", "second beat order",
          64'(beat_data[base + 1]), 64'h7777_0002);

      idle(2);
      summary();
      $finish;
   end

endmodule